// File: doc/BRIEF.md
# Frame-Periodic Automatic Gain Controller

This block steers the global gain of an image sensor from the colour statistics the pipeline gathers each frame. A frame tick paces it. An enable input switches it on or off. A request/response port reads the present gain from the sensor, and a second request/done port writes registers back to it.

While the block is enabled, it counts accepted frame ticks and acts on one frame out of every fourteen. On that frame it captures four colour sums (first green, red, blue, second green). It reads the sensor's present gain and forms a weighted luma value using fixed shift-and-add arithmetic. If the luma lies outside a dead band around mid-scale, it computes a clamped new gain. It then writes an unlock value to the sensor, followed by the new gain.

While an update is in flight, the block accepts no further frame ticks. The statistics source, the sensor bus transport and exposure control lie outside it.

Top module: `agc_frame_ctrl`

## Requirements
- R1: After the enable rises, the first update starts on the 14th accepted frame tick. Each later update starts on every further 14th accepted tick. An update starts by raising `rd_req` in the cycle after the tick is sampled.
- R2: While `agc_en` is low, no update starts, whatever ticks arrive. When `agc_en` rises again, the count restarts, so the next update needs a full 14 ticks.
- R3: Frame ticks that arrive while an update is in flight are ignored and do not advance the frame count.
- R4: A gain read holds `rd_req` high with `rd_addr` = 0x0E until `rd_valid` is seen. `rd_data` is taken as the present gain in that cycle.
- R5: The statistics are captured in the cycle the update starts. Green is (G1+G2)>>1. Luma is the sum of three weighted terms, saturated to 0..255:
  - (R·232)>>10
  - (G·672)>>10
  - (B·128)>>10
- R6: When luma lies within 108..148 inclusive, the update ends without any write. When luma is below 108 or above 148, a write sequence follows.
- R7: The candidate gain is the present gain plus ((128 − luma) arithmetically shifted right by 4), which rounds toward minus infinity.
- R8: A candidate above 31 is written as 31. A candidate below 4 is written as 3. A candidate from 4 to 31 is written unchanged.
- R9: The write sequence has two transfers, each held with `wr_req` high until `wr_done`:
  - first, address 0x13, data 0x01, mode 3;
  - then, address 0x0E, the new gain, mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| agc_en | input | 1 | Automatic gain enable |
| stat_g1 | input | 8 | First green statistic |
| stat_r | input | 8 | Red statistic |
| stat_b | input | 8 | Blue statistic |
| stat_g2 | input | 8 | Second green statistic |
| rd_req | output | 1 | Gain read request, held until rd_valid |
| rd_addr | output | 8 | Sensor register to read |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |
| wr_req | output | 1 | Write request, held until wr_done |
| wr_addr | output | 8 | Sensor register to write |
| wr_data | output | 8 | Write data |
| wr_mode | output | 2 | Transfer mode of the write |
| wr_done | input | 1 | Write complete |

## Verification
The hardest situation to reach is a frame tick that lands while an update is still in flight. If such a tick silently advanced the count, the effect would appear only one full period later. The bench slows the read response far enough to push five extra ticks in behind the update tick. It then requires the next update to take exactly fourteen ticks. Luma values exactly on both dead-band edges and one step outside them are found by a search over the model, so that the band limits are hit exactly.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [2:0] {
    AGC_IDLE,
    AGC_READ,
    AGC_CALC,
    AGC_UNLOCK,
    AGC_GAIN
  } agc_state_t;

  localparam logic [7:0] GAIN_REG_DEF   = 8'h0e;
  localparam logic [7:0] UNLOCK_REG_DEF = 8'h13;
  localparam logic [7:0] UNLOCK_VAL_DEF = 8'h01;
  localparam logic [1:0] UNLOCK_MODE_DEF = 2'd3;
  localparam logic [1:0] GAIN_MODE_DEF   = 2'd1;
endpackage

// File: rtl/agc_skip_counter.sv
module agc_skip_counter #(
  parameter int RELOAD = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick_ok,
  output logic fire
);
  localparam int CW = $clog2(RELOAD + 1) + 1;
  localparam logic signed [CW-1:0] LOAD = CW'(RELOAD);
  localparam logic signed [CW-1:0] OFF  = '1;
  localparam logic signed [CW-1:0] ONE  = CW'(1);

  logic signed [CW-1:0] cnt;
  logic                 en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= OFF;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (!en) begin
        cnt <= OFF;
      end else if (!en_q) begin
        cnt <= LOAD;
      end else if (tick_ok && !cnt[CW-1]) begin
        cnt <= (cnt == '0) ? LOAD : cnt - ONE;
      end
    end
  end

  assign fire = en && en_q && tick_ok && (cnt == '0);
endmodule

// File: rtl/agc_luma.sv
module agc_luma #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] g1,
  input  logic [PW-1:0] r,
  input  logic [PW-1:0] b,
  input  logic [PW-1:0] g2,
  output logic [PW-1:0] luma
);
  localparam int WW = PW + 11;
  localparam int FRAC = 10;
  localparam logic [PW-1:0] LMAX = {PW{1'b1}};

  logic [WW-1:0] g_sum, g_avg, r_ext, b_ext;
  logic [WW-1:0] r_term, g_term, b_term, total;

  always_comb begin
    g_sum  = WW'(g1) + WW'(g2);
    g_avg  = g_sum >> 1;
    r_ext  = WW'(r);
    b_ext  = WW'(b);
    // red weight 232 = 256 - 16 - 8, green 672 = 512 + 128 + 32, blue 128
    r_term = ((r_ext << 8) - (r_ext << 4) - (r_ext << 3)) >> FRAC;
    g_term = ((g_avg << 9) + (g_avg << 7) + (g_avg << 5)) >> FRAC;
    b_term = (b_ext << 7) >> FRAC;
    total  = r_term + g_term + b_term;
    luma   = (total > WW'(LMAX)) ? LMAX : total[PW-1:0];
  end
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
  parameter int GW     = 8,
  parameter int SW     = 10,
  parameter int TARGET = 128,
  parameter int BAND   = 20,
  parameter int SPRING = 4,
  parameter int GMAX   = 31,
  parameter int GMIN   = 4,
  parameter int GFLOOR = 3
) (
  input  logic [GW-1:0] cur,
  input  logic [GW-1:0] luma,
  output logic          adjust,
  output logic [GW-1:0] gain_out
);
  localparam logic signed [SW-1:0] TGT_S = SW'(TARGET);
  localparam logic signed [SW-1:0] LO_S  = SW'(TARGET - BAND);
  localparam logic signed [SW-1:0] HI_S  = SW'(TARGET + BAND);
  localparam logic signed [SW-1:0] MAX_S = SW'(GMAX);
  localparam logic signed [SW-1:0] MIN_S = SW'(GMIN);

  logic signed [SW-1:0] cur_s, luma_s, diff, step, cand;

  always_comb begin
    cur_s  = $signed({{(SW-GW){1'b0}}, cur});
    luma_s = $signed({{(SW-GW){1'b0}}, luma});
    diff   = TGT_S - luma_s;
    step   = diff >>> SPRING;
    cand   = cur_s + step;
    adjust = (luma_s < LO_S) || (luma_s > HI_S);
    if (cand > MAX_S)
      gain_out = GW'(GMAX);
    else if (cand < MIN_S)
      gain_out = GW'(GFLOOR);
    else
      gain_out = cand[GW-1:0];
  end
endmodule

// File: rtl/agc_frame_ctrl.sv
module agc_frame_ctrl
  import agc_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int MW = 2,
  parameter int SKIP = 13,
  parameter logic [AW-1:0] GAIN_REG    = AW'(GAIN_REG_DEF),
  parameter logic [AW-1:0] UNLOCK_REG  = AW'(UNLOCK_REG_DEF),
  parameter logic [DW-1:0] UNLOCK_VAL  = DW'(UNLOCK_VAL_DEF),
  parameter logic [MW-1:0] UNLOCK_MODE = MW'(UNLOCK_MODE_DEF),
  parameter logic [MW-1:0] GAIN_MODE   = MW'(GAIN_MODE_DEF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_tick,
  input  logic          agc_en,
  input  logic [DW-1:0] stat_g1,
  input  logic [DW-1:0] stat_r,
  input  logic [DW-1:0] stat_b,
  input  logic [DW-1:0] stat_g2,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [MW-1:0] wr_mode,
  input  logic          wr_done
);
  agc_state_t    state;
  logic          tick_ok, fire, adjust;
  logic [DW-1:0] cap_g1, cap_r, cap_b, cap_g2;
  logic [DW-1:0] cur_gain, new_gain, luma, gain_calc;

  assign tick_ok = frame_tick && (state == AGC_IDLE);

  agc_skip_counter #(.RELOAD(SKIP)) u_skip (
    .clk(clk), .rst(rst), .en(agc_en), .tick_ok(tick_ok), .fire(fire)
  );

  agc_luma #(.PW(DW)) u_luma (
    .g1(cap_g1), .r(cap_r), .b(cap_b), .g2(cap_g2), .luma(luma)
  );

  agc_gain_step #(.GW(DW), .SW(DW + 2)) u_step (
    .cur(cur_gain), .luma(luma), .adjust(adjust), .gain_out(gain_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= AGC_IDLE;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_mode  <= '0;
      cap_g1   <= '0;
      cap_r    <= '0;
      cap_b    <= '0;
      cap_g2   <= '0;
      cur_gain <= '0;
      new_gain <= '0;
    end else begin
      case (state)
        AGC_IDLE: begin
          if (fire) begin
            cap_g1  <= stat_g1;
            cap_r   <= stat_r;
            cap_b   <= stat_b;
            cap_g2  <= stat_g2;
            rd_req  <= 1'b1;
            rd_addr <= GAIN_REG;
            state   <= AGC_READ;
          end
        end
        AGC_READ: begin
          if (rd_valid) begin
            cur_gain <= rd_data;
            rd_req   <= 1'b0;
            state    <= AGC_CALC;
          end
        end
        AGC_CALC: begin
          if (adjust) begin
            new_gain <= gain_calc;
            wr_req   <= 1'b1;
            wr_addr  <= UNLOCK_REG;
            wr_data  <= UNLOCK_VAL;
            wr_mode  <= UNLOCK_MODE;
            state    <= AGC_UNLOCK;
          end else begin
            state <= AGC_IDLE;
          end
        end
        AGC_UNLOCK: begin
          if (wr_done) begin
            wr_addr <= GAIN_REG;
            wr_data <= new_gain;
            wr_mode <= GAIN_MODE;
            state   <= AGC_GAIN;
          end
        end
        AGC_GAIN: begin
          if (wr_done) begin
            wr_req <= 1'b0;
            state  <= AGC_IDLE;
          end
        end
        default: state <= AGC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/agc_checker.sv
module agc_checker #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int MW = 2,
  parameter logic [AW-1:0] GAIN_REG   = 8'h0e,
  parameter logic [AW-1:0] UNLOCK_REG = 8'h13
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_tick,
  input logic          agc_en,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [MW-1:0] wr_mode,
  input logic          wr_done
);
  // R1 R2: a read only starts right after an enabled frame tick
  assert_start_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> ($past(frame_tick) && $past(agc_en)));

  // R4: read request held with the gain address until valid
  assert_read_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && rd_addr == GAIN_REG));

  // R3: read and write never overlap (one update at a time)
  assert_one_update_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  // R9: a pending write keeps its fields until done
  assert_write_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_mode)));

  // R9: gain write follows a completed unlock write
  assert_unlock_first_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_addr == GAIN_REG && !($past(wr_req) && $past(wr_addr) == GAIN_REG))
      |-> ($past(wr_addr) == UNLOCK_REG && $past(wr_done)));

  // R8: gain written stays inside the clamp range with mode 1
  assert_gain_range_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_addr == GAIN_REG) |-> (wr_data >= 3 && wr_data <= 31 && wr_mode == 1));
endmodule

bind agc_frame_ctrl agc_checker #(
  .DW(DW), .AW(AW), .MW(MW), .GAIN_REG(GAIN_REG), .UNLOCK_REG(UNLOCK_REG)
) u_agc_checker (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .agc_en(agc_en),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_mode(wr_mode), .wr_done(wr_done)
);

// File: tb/tb_agc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_agc_frame_ctrl;
  logic clk = 1'b0;
  logic rst, frame_tick, agc_en;
  logic [7:0] stat_g1, stat_r, stat_b, stat_g2;
  logic rd_req, rd_valid, wr_req, wr_done;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [1:0] wr_mode;

  always #2.5 clk = ~clk;

  agc_frame_ctrl dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .agc_en(agc_en),
    .stat_g1(stat_g1), .stat_r(stat_r), .stat_b(stat_b), .stat_g2(stat_g2),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mode(wr_mode),
    .wr_done(wr_done)
  );

  int n_checks = 0;
  int n_err = 0;
  int rd_lat = 3;
  int wr_lat = 2;
  logic [7:0] gain_src = 8'd10;
  logic [17:0] exp_q[$];
  logic [17:0] got, want;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_luma(int g1, int r, int b, int g2);
    int g, s;
    g = (g1 + g2) / 2;
    s = (r * 232) / 1024 + (g * 672) / 1024 + (b * 128) / 1024;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int model_gain(int cur, int lm);
    int d, st, n;
    d = 128 - lm;
    st = (d >= 0) ? d / 16 : -((-d + 15) / 16);
    n = cur + st;
    if (n > 31) return 31;
    if (n < 4) return 3;
    return n;
  endfunction

  function automatic logic [15:0] find_stat(int target);
    for (int gv = 0; gv < 256; gv++)
      for (int bv = 0; bv < 256; bv++)
        if (model_luma(gv, 0, bv, gv) == target) return {gv[7:0], bv[7:0]};
    return 16'h0;
  endfunction

  // read responder
  initial begin
    rd_valid = 1'b0;
    rd_data = 8'h00;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        chk(rd_addr == 8'h0e, "R4 read address", rd_addr, 14);
        repeat (rd_lat) @(negedge clk);
        chk(rd_req == 1'b1, "R4 request held", rd_req, 1);
        rd_data = gain_src;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  // write monitor: pops expected transfers from the scoreboard
  initial begin
    wr_done = 1'b0;
    forever begin
      @(negedge clk);
      if (wr_req) begin
        repeat (wr_lat) @(negedge clk);
        got = {wr_addr, wr_data, wr_mode};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R9 unexpected write", int'(got), 0);
        end else begin
          want = exp_q.pop_front();
          chk(got == want, "R9/R7/R8 write transfer", int'(got), int'(want));
        end
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
      end
    end
  end

  task automatic tick_once();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic no_start_ticks(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick_once();
      chk(rd_req == 1'b0, req, rd_req, 0);
    end
  endtask

  task automatic period(input int extra);
    for (int i = 1; i <= 14; i++) begin
      tick_once();
      if (i < 14) begin
        if (rd_req) chk(1'b0, "R1 early start", i, 14);
      end else begin
        chk(rd_req == 1'b1, "R1 start on 14th tick", rd_req, 1);
      end
    end
    for (int i = 0; i < extra; i++) tick_once();
    repeat (80) @(negedge clk);
  endtask

  task automatic update_case(input int cur, input int g1, input int r,
                             input int b, input int g2, input string tag);
    int lm, ng;
    gain_src = cur[7:0];
    stat_g1 = g1[7:0]; stat_r = r[7:0]; stat_b = b[7:0]; stat_g2 = g2[7:0];
    lm = model_luma(g1, r, b, g2);
    ng = model_gain(cur, lm);
    if (lm < 108 || lm > 148) begin
      exp_q.push_back({8'h13, 8'h01, 2'd3});
      exp_q.push_back({8'h0e, ng[7:0], 2'd1});
    end
    period(0);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    logic [15:0] s;
    rst = 1'b1; frame_tick = 1'b0; agc_en = 1'b0;
    stat_g1 = 0; stat_r = 0; stat_b = 0; stat_g2 = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_req == 1'b0, "R4 reset rd_req", rd_req, 0);
    chk(wr_req == 1'b0, "R9 reset wr_req", wr_req, 0);

    no_start_ticks(20, "R2 disabled no start");

    agc_en = 1'b1;
    repeat (2) @(negedge clk);

    update_case(10, 0, 0, 0, 0, "R7 dark step up");
    update_case(20, 255, 255, 255, 255, "R5 R7 bright step down");
    update_case(30, 0, 0, 0, 0, "R8 clamp high");
    update_case(8, 255, 255, 255, 255, "R8 clamp low to 3");
    update_case(12, 255, 255, 255, 255, "R8 exactly 4 kept");
    update_case(200, 255, 255, 255, 255, "R8 large read value");
    s = find_stat(107);
    update_case(10, s[15:8], 0, s[7:0], s[15:8], "R6 luma 107 updates");
    s = find_stat(108);
    update_case(10, s[15:8], 0, s[7:0], s[15:8], "R6 luma 108 no write");
    s = find_stat(148);
    update_case(10, s[15:8], 0, s[7:0], s[15:8], "R6 luma 148 no write");
    s = find_stat(149);
    update_case(10, s[15:8], 0, s[7:0], s[15:8], "R6 luma 149 updates");
    update_case(10, 128, 128, 128, 128, "R6 mid luma no write");
    update_case(16, 0, 100, 50, 201, "R5 green average");

    // R3: ticks during an in-flight update must not count
    rd_lat = 20;
    gain_src = 8'd10;
    stat_g1 = 0; stat_r = 0; stat_b = 0; stat_g2 = 0;
    exp_q.push_back({8'h13, 8'h01, 2'd3});
    exp_q.push_back({8'h0e, 8'd18, 2'd1});
    period(5);
    chk(exp_q.size() == 0, "R3 busy update done", exp_q.size(), 0);
    rd_lat = 3;
    update_case(10, 0, 0, 0, 0, "R3 next period full length");

    // R2: disable mid-count, then re-enable restarts the count
    no_start_ticks(5, "R2 partial count");
    agc_en = 1'b0;
    repeat (2) @(negedge clk);
    no_start_ticks(20, "R2 disabled again");
    agc_en = 1'b1;
    repeat (2) @(negedge clk);
    update_case(10, 0, 0, 0, 0, "R2 reload after enable");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule